// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block holds the four segment bases of a 16-bit processor datapath (code, data, stack and extra) and turns a segment:offset pair into a physical memory address. The segment value is shifted left by a parameterised amount and then added to the 16-bit offset. It is not concatenated with it. Segments therefore begin on 16-byte (or 256-byte) boundaries, they may overlap, and many different pairs reach the same byte.

A register port writes and reads the segment bases. An address request gives a segment select and an offset under a valid strobe. The physical address is registered and appears one cycle later with its own valid flag. A normalize output restates the held physical address as the equivalent pair whose offset is as small as possible. If a write and a request name the same segment in the same cycle, the request uses the new value.

Top module: `segaddr_gen`

## Requirements
- R1: A write (`wr_en`, `wr_sel`, `wr_data`) updates the chosen segment register at the clock edge. `rd_data` shows the register named by `rd_sel` combinationally, so a write becomes visible there from the next cycle on.
- R2: The segment select encoding is the same on every port: 2'b00 extra, 2'b01 code, 2'b10 stack, 2'b11 data.
- R3: While `rst` is high, the code register is set to all ones (0xFFFF) and the other three registers are cleared. At the same time `pa_valid` and `pa_addr` go to zero.
- R4: A request with `req_valid` high produces `pa_valid` high in the next cycle, with `pa_addr` = (segment << SHIFT) + offset, taken modulo 2^(16+SHIFT). `pa_valid` is low in the cycle after a cycle with no request.
- R5: Aliasing pairs resolve to one byte. For example, 0x0000:0x00FF and 0x000F:0x000F both give 0x000FF.
- R6: Sums that carry out of the address width wrap. With SHIFT=4, 0xFFFF:0x0010 gives 0x00000 and 0xFFFF:0xFFFF gives 0x0FFEF.
- R7: If a write and a request name the same segment in the same cycle, the address is computed from the newly written value.
- R8: When no request is made, `pa_addr` keeps its previous value. A write in such a cycle does not change it.
- R9: `norm_seg` equals `pa_addr` shifted right by SHIFT, and `norm_off` equals the low SHIFT bits of `pa_addr`.
- R10: With SHIFT=8 the address is 24 bits wide and bases align to 256 bytes. For example, 0x1234:0x0056 gives 0x123456, and 0xFFFF:0x0010 gives 0xFFFF10.
- R11: When all four registers hold zero, every select maps the offset straight to the same physical address, which gives one flat 64 KB space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Register to write |
| wr_data | input | SEG_W | Value to write |
| rd_sel | input | 2 | Register to read |
| rd_data | output | SEG_W | Contents of the register named by rd_sel |
| req_valid | input | 1 | Address request strobe |
| req_sel | input | 2 | Segment used by the request |
| req_off | input | OFF_W | Request offset |
| pa_valid | output | 1 | Registered address is fresh this cycle |
| pa_addr | output | SEG_W+SHIFT | Registered physical address |
| norm_seg | output | SEG_W | Normalized segment of pa_addr |
| norm_off | output | SHIFT | Normalized offset of pa_addr |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any traffic. They also assume that the select, data and offset inputs never carry unknown values while their strobes are high. The comparisons that look at the previous cycle are gated, so they only start once one full cycle has passed since reset. The bench enforces these assumptions: it asserts reset from time zero, drives every input to a known value at each falling edge, and keeps both strobes low except inside the tasks that use them. Both shift settings are instantiated side by side on shared inputs, so the same stimulus covers the 16-byte and the 256-byte alignment.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEL_W    = 2;
  localparam int NUM_SEGS = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_EXTRA = 2'b00,
    SEL_CODE  = 2'b01,
    SEL_STACK = 2'b10,
    SEL_DATA  = 2'b11
  } seg_sel_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_data,
  input  logic [SEL_W-1:0] fw_sel,
  output logic [SEG_W-1:0] fw_data
);
  logic [SEG_W-1:0] bank [NUM_SEGS];

  // one register per segment, each with its own reset value
  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL =
      (g == int'(SEL_CODE)) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[g] <= RST_VAL;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        bank[g] <= wr_data;
      end
    end
  end

  assign rd_data = bank[rd_sel];

  // same-cycle bypass so a request sees a write to its own segment
  always_comb begin
    if (wr_en && (wr_sel == fw_sel)) fw_data = wr_data;
    else                             fw_data = bank[fw_sel];
  end
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg_base,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  phys
);
  logic [PA_W-1:0] base_ext;
  logic [PA_W-1:0] off_ext;

  assign base_ext = {seg_base, {SHIFT{1'b0}}};
  assign off_ext  = PA_W'(offset);
  // carry out of the top bit is dropped: modulo wrap
  assign phys     = base_ext + off_ext;
endmodule

// File: rtl/seg_normalize.sv
module seg_normalize #(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [PA_W-1:0]  phys,
  output logic [SEG_W-1:0] n_seg,
  output logic [SHIFT-1:0] n_off
);
  assign n_seg = phys[PA_W-1:SHIFT];
  assign n_off = phys[SHIFT-1:0];
endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [SEG_W-1:0] rd_data,
  input  logic             req_valid,
  input  logic [1:0]       req_sel,
  input  logic [OFF_W-1:0] req_off,
  output logic             pa_valid,
  output logic [PA_W-1:0]  pa_addr,
  output logic [SEG_W-1:0] norm_seg,
  output logic [SHIFT-1:0] norm_off
);
  logic [SEG_W-1:0] req_base;
  logic [PA_W-1:0]  pa_next;
  logic [PA_W-1:0]  pa_q;
  logic             vld_q;

  seg_regfile #(.SEG_W(SEG_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .fw_sel  (req_sel),
    .fw_data (req_base)
  );

  seg_addr_calc #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_calc (
    .seg_base (req_base),
    .offset   (req_off),
    .phys     (pa_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      pa_q  <= '0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) pa_q <= pa_next;
    end
  end

  assign pa_valid = vld_q;
  assign pa_addr  = pa_q;

  seg_normalize #(.SEG_W(SEG_W), .SHIFT(SHIFT)) u_norm (
    .phys  (pa_q),
    .n_seg (norm_seg),
    .n_off (norm_off)
  );
endmodule

// File: rtl/segaddr_gen_chk.sv
module segaddr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [SEG_W-1:0] wr_data,
  input logic [1:0]       rd_sel,
  input logic [SEG_W-1:0] rd_data,
  input logic             req_valid,
  input logic [1:0]       req_sel,
  input logic [OFF_W-1:0] req_off,
  input logic             pa_valid,
  input logic [PA_W-1:0]  pa_addr,
  input logic [SEG_W-1:0] norm_seg,
  input logic [SHIFT-1:0] norm_off
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!pa_valid && pa_addr == '0));

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (pa_valid == $past(req_valid)));

  // R1
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(wr_en) && rd_sel == $past(wr_sel)) |-> (rd_data == $past(wr_data)));

  // R7
  fwd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(req_valid && wr_en && (wr_sel == req_sel))) |->
      (pa_addr == ((PA_W'($past(wr_data)) << SHIFT) + PA_W'($past(req_off)))));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(req_valid)) |-> ($stable(pa_addr) && !pa_valid));

  // R9
  norm_rebuild_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (((PA_W'(norm_seg) << SHIFT) | PA_W'(norm_off)) == pa_addr));
endmodule

bind segaddr_gen segaddr_gen_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel(rd_sel), .rd_data(rd_data), .req_valid(req_valid), .req_sel(req_sel),
  .req_off(req_off), .pa_valid(pa_valid), .pa_addr(pa_addr),
  .norm_seg(norm_seg), .norm_off(norm_off)
);

// File: tb/segaddr_gen_tb.sv
`timescale 1ns/1ps
module segaddr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [1:0]  rd_sel = 2'b00;
  logic        req_valid = 1'b0;
  logic [1:0]  req_sel = 2'b00;
  logic [15:0] req_off = 16'h0;

  logic [15:0] rd_data, rd_data8;
  logic        pa_valid, pa_valid8;
  logic [19:0] pa_addr;
  logic [23:0] pa_addr8;
  logic [15:0] norm_seg, norm_seg8;
  logic [3:0]  norm_off;
  logic [7:0]  norm_off8;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  segaddr_gen #(.SHIFT(4)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .req_valid(req_valid), .req_sel(req_sel),
    .req_off(req_off), .pa_valid(pa_valid), .pa_addr(pa_addr),
    .norm_seg(norm_seg), .norm_off(norm_off)
  );

  segaddr_gen #(.SHIFT(8)) u_dut8 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data8), .req_valid(req_valid), .req_sel(req_sel),
    .req_off(req_off), .pa_valid(pa_valid8), .pa_addr(pa_addr8),
    .norm_seg(norm_seg8), .norm_off(norm_off8)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [15:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // request: drives for one edge, then samples at the following falling edge
  task automatic do_req(input logic [1:0] sel, input logic [15:0] off);
    req_valid = 1'b1; req_sel = sel; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R3 pa_valid", {31'b0, pa_valid}, 32'h0);
    check("R3 pa_addr", {12'b0, pa_addr}, 32'h0);
    rd_sel = 2'b01; #0.1;
    check("R3 code reset", {16'b0, rd_data}, 32'hFFFF);
    for (int s = 0; s < 4; s++) begin
      if (s != 1) begin
        rd_sel = 2'(s); #0.1;
        check("R3 other reset", {16'b0, rd_data}, 32'h0);
      end
    end
  endtask

  task automatic t_wrap_reset_code();
    do_req(2'b01, 16'h0010);
    check("R6 wrap pa", {12'b0, pa_addr}, 32'h00000);
    check("R4 pa_valid", {31'b0, pa_valid}, 32'h1);
    check("R10 wide code", {8'b0, pa_addr8}, 32'hFFFF10);
    do_req(2'b01, 16'hFFFF);
    check("R6 wrap max", {12'b0, pa_addr}, 32'h0FFEF);
  endtask

  task automatic t_encoding();
    do_write(2'b00, 16'h1111);
    do_write(2'b01, 16'h2222);
    do_write(2'b10, 16'h3333);
    do_write(2'b11, 16'h4444);
    rd_sel = 2'b00; #0.1; check("R2 extra", {16'b0, rd_data}, 32'h1111);
    rd_sel = 2'b01; #0.1; check("R2 code",  {16'b0, rd_data}, 32'h2222);
    rd_sel = 2'b10; #0.1; check("R1 R2 stack", {16'b0, rd_data}, 32'h3333);
    rd_sel = 2'b11; #0.1; check("R2 data",  {16'b0, rd_data}, 32'h4444);
    do_req(2'b10, 16'h0000);
    check("R2 R4 stack req", {12'b0, pa_addr}, 32'h33330);
  endtask

  task automatic t_flat();
    for (int s = 0; s < 4; s++) do_write(2'(s), 16'h0000);
    for (int s = 0; s < 4; s++) begin
      do_req(2'(s), 16'hABCD);
      check("R11 flat", {12'b0, pa_addr}, 32'h0ABCD);
    end
  endtask

  task automatic t_alias();
    do_write(2'b00, 16'h0000);
    do_write(2'b11, 16'h000F);
    do_req(2'b00, 16'h00FF);
    check("R5 alias a", {12'b0, pa_addr}, 32'h000FF);
    do_req(2'b11, 16'h000F);
    check("R5 alias b", {12'b0, pa_addr}, 32'h000FF);
    check("R9 norm seg", {16'b0, norm_seg}, 32'h000F);
    check("R9 norm off", {28'b0, norm_off}, 32'hF);
  endtask

  task automatic t_forward();
    wr_en = 1'b1; wr_sel = 2'b11; wr_data = 16'h5000;
    req_valid = 1'b1; req_sel = 2'b11; req_off = 16'h0123;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R7 forward", {12'b0, pa_addr}, 32'h50123);
    check("R7 valid", {31'b0, pa_valid}, 32'h1);
  endtask

  task automatic t_hold();
    do_write(2'b11, 16'h7777);
    check("R8 hold after write", {12'b0, pa_addr}, 32'h50123);
    check("R4 R8 valid low", {31'b0, pa_valid}, 32'h0);
    req_off = 16'h9999; req_sel = 2'b11;
    @(negedge clk);
    check("R8 hold idle", {12'b0, pa_addr}, 32'h50123);
  endtask

  task automatic t_wide();
    do_write(2'b11, 16'h1234);
    do_req(2'b11, 16'h0056);
    check("R10 wide pa", {8'b0, pa_addr8}, 32'h123456);
    check("R4 narrow pa", {12'b0, pa_addr}, 32'h12396);
    check("R9 narrow norm seg", {16'b0, norm_seg}, 32'h1239);
    check("R9 narrow norm off", {28'b0, norm_off}, 32'h6);
    check("R9 R10 wide norm seg", {16'b0, norm_seg8}, 32'h1234);
    check("R9 R10 wide norm off", {24'b0, norm_off8}, 32'h56);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_wrap_reset_code();
    t_encoding();
    t_flat();
    t_alias();
    t_forward();
    t_hold();
    t_wide();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule